// File: doc/BRIEF.md
# MICROWIRE Master Frame Engine

This block is the master side of a half-duplex three-wire serial link. Each frame opens with an 8-bit command sent most significant bit first. One idle turnaround bit follows, in which the slave returns a zero. The slave then answers with a word of programmable length, also most significant bit first. The engine drives the serial clock, the active-low frame select and the transmit line, and it samples the receive line. It hands the answer to the system as a right-justified word, together with a single-cycle done strobe.

The bit clock comes from the system clock through two dividers in cascade: a prescaler set by an even divisor, then a rate stage that divides by one plus a rate value. Timing and length settings are captured only while the engine is disabled and idle. Holding the enable high at the end of a frame starts the next frame at once, with frame select still low. The command input is sampled at the start of each frame. Dropping the enable lets the current frame finish before frame select is released.

Top module: `uwire_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `fss_n` is high and `sclk`, `txd` and `done` are low; `rsp_data` resets to zero.
- R2: When a frame starts from idle, `fss_n` falls, and the first rising `sclk` edge comes no sooner than two bit periods later.
- R3: The 8 bits of `cmd_byte`, captured at frame start, appear on `txd` most significant bit first. Each bit is valid at a rising `sclk` edge, and `txd` changes only after a falling edge.
- R4: The ninth bit period is a turnaround that is not captured. The next `rsp_len` bits on `rxd` are sampled on rising `sclk` edges, most significant bit first. `txd` is low from the turnaround to the end of the frame.
- R5: `done` is a one-cycle pulse in the cycle in which `sclk` rises for the last response bit. From that cycle on, `rsp_data` holds the response right-justified, with every bit above the response length at zero.
- R6: With an effective divisor P = `psc_div` with bit 0 cleared (values below 2 act as 2) and rate value S = `scr_val`, the bit period is P*(1+S) system clocks. `sclk` is high for exactly half of each period and changes only on half-period steps.
- R7: A `rsp_len` below 4 acts as 4 and one above 16 acts as 16.
- R8: If `enable` is high when the last response bit ends, `fss_n` stays low and the next command's first rising edge follows one bit period after the previous rising edge. `fss_n` rises only when `enable` was low at that point.
- R9: `psc_div`, `scr_val` and `rsp_len` are captured only while the engine is idle and disabled. Changes made while enabled or while a frame is running have no effect on the frames in progress.
- R10: Lowering `enable` in the middle of a frame lets that frame complete with its `done` pulse. `fss_n` then returns high at the frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run frames while high; captured settings update while low and idle |
| cmd_byte | input | 8 | Command word sent at the start of each frame |
| rsp_len | input | 5 | Response length in bits, clamped to 4..16 |
| psc_div | input | 8 | Prescale divisor, even, 2..254 |
| scr_val | input | 8 | Rate value, bit clock divided by one plus this value |
| rxd | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| fss_n | output | 1 | Active-low frame select |
| txd | output | 1 | Serial data to the slave |
| rsp_data | output | 16 | Last received response, right-justified |
| done | output | 1 | One-cycle strobe when a response is complete |

## Verification
The bound checker watches the quiet state of the lines outside a frame on every cycle. It also checks that the done pulse is one cycle wide and lands on a high clock, that the serial clock moves only on divider steps, and that the captured settings stay frozen while the engine is busy. It also checks that frame select rises only after the enable was seen low. Only the bench's slave model can show that the command bits arrive in order and that the response is assembled right-justified. The same holds for the exact bit period and lead time under several divisor settings, the length clamping, and that frames run back to back without a gap. That a setting written mid-burst really has no effect is shown by timing measured against the earlier values.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_RUN  = 2'd2
   } uw_state_e;

endpackage

// File: rtl/uwire_cfg.sv
module uwire_cfg #(
   parameter int PSC_W     = 8,
   parameter int SCR_W     = 8,
   parameter int LEN_W     = 5,
   parameter int MIN_RSP_W = 4,
   parameter int MAX_RSP_W = 16,
   localparam int HW       = PSC_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PSC_W-1:0] psc_in,
   input  logic [SCR_W-1:0] scr_in,
   input  logic [LEN_W-1:0] len_in,
   output logic [HW-1:0]    half_q,
   output logic [SCR_W-1:0] scr_q,
   output logic [LEN_W-1:0] len_q
);

   logic [HW-1:0]    half_d;
   logic [LEN_W-1:0] len_d;

   // Half of the even divisor; a zero result is raised to one.
   always_comb begin
      half_d = HW'(psc_in >> 1);
      if (half_d == '0) half_d = HW'(1);
   end

   always_comb begin
      if (int'(len_in) < MIN_RSP_W)      len_d = LEN_W'(MIN_RSP_W);
      else if (int'(len_in) > MAX_RSP_W) len_d = LEN_W'(MAX_RSP_W);
      else                               len_d = len_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= HW'(1);
         scr_q  <= '0;
         len_q  <= LEN_W'(MIN_RSP_W);
      end else if (load) begin
         half_q <= half_d;
         scr_q  <= scr_in;
         len_q  <= len_d;
      end
   end

endmodule

// File: rtl/uwire_clkdiv.sv
module uwire_clkdiv #(
   parameter int HW    = 7,
   parameter int SCR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [HW-1:0]    half,
   input  logic [SCR_W-1:0] scr,
   output logic             hstep
);

   logic [HW-1:0]    pcnt;
   logic [SCR_W-1:0] scnt;
   logic             pend;
   logic             send;

   assign pend  = (pcnt == half - HW'(1));
   assign send  = (scnt == scr);
   assign hstep = run && pend && send;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         scnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
         scnt <= '0;
      end else if (pend) begin
         pcnt <= '0;
         scnt <= send ? '0 : scnt + SCR_W'(1);
      end else begin
         pcnt <= pcnt + HW'(1);
      end
   end

endmodule

// File: rtl/uwire_shift.sv
module uwire_shift #(
   parameter int CMD_W = 8,
   parameter int RSP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic             tx_adv,
   input  logic             rx_cap,
   input  logic             rxd,
   output logic             tx_bit,
   output logic [RSP_W-1:0] rx_next
);

   logic [CMD_W-1:0] csh;
   logic [RSP_W-1:0] rsh;

   assign tx_bit  = csh[CMD_W-1];
   assign rx_next = RSP_W'({rsh, rxd});

   // Clearing at frame start leaves a short response right-justified.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csh <= '0;
         rsh <= '0;
      end else if (load) begin
         csh <= cmd_in;
         rsh <= '0;
      end else begin
         if (tx_adv) csh <= csh << 1;
         if (rx_cap) rsh <= rx_next;
      end
   end

endmodule

// File: rtl/uwire_master.sv
module uwire_master #(
   parameter int CMD_W      = 8,
   parameter int MIN_RSP_W  = 4,
   parameter int MAX_RSP_W  = 16,
   parameter int PSC_W      = 8,
   parameter int SCR_W      = 8,
   parameter int LEAD_STEPS = 4,
   localparam int LEN_W     = $clog2(MAX_RSP_W + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [CMD_W-1:0]     cmd_byte,
   input  logic [LEN_W-1:0]     rsp_len,
   input  logic [PSC_W-1:0]     psc_div,
   input  logic [SCR_W-1:0]     scr_val,
   input  logic                 rxd,
   output logic                 sclk,
   output logic                 fss_n,
   output logic                 txd,
   output logic [MAX_RSP_W-1:0] rsp_data,
   output logic                 done
);
   import uwire_pkg::*;

   localparam int HW     = PSC_W - 1;
   localparam int BITN_W = $clog2(CMD_W + MAX_RSP_W + 2);
   localparam int LCNT_W = $clog2(LEAD_STEPS);

   if (MIN_RSP_W < 1 || MAX_RSP_W < MIN_RSP_W) begin : g_bad_len
      initial $fatal(1, "response length bounds are inconsistent");
   end
   if (CMD_W < 2 || PSC_W < 2 || SCR_W < 1) begin : g_bad_width
      initial $fatal(1, "command, prescale or rate width too small");
   end
   if (LEAD_STEPS < 4 || (1 << LCNT_W) != LEAD_STEPS) begin : g_bad_lead
      initial $fatal(1, "lead must be a power of two of at least four half steps");
   end

   uw_state_e            state;
   logic [BITN_W-1:0]    bitn;
   logic [LCNT_W-1:0]    lcnt;
   logic                 sclk_q;
   logic                 fss_q;
   logic                 done_q;
   logic [MAX_RSP_W-1:0] rsp_q;

   logic [HW-1:0]        half_q;
   logic [SCR_W-1:0]     scr_q;
   logic [LEN_W-1:0]     len_q;
   logic                 hstep;
   logic                 busy;
   logic                 tx_bit;
   logic [MAX_RSP_W-1:0] rx_next;

   logic [BITN_W-1:0]    last_idx;
   logic                 at_last;
   logic                 run_rise;
   logic                 run_fall;
   logic                 frame_start;
   logic                 tx_adv;
   logic                 rx_cap;

   assign busy        = (state != ST_IDLE);
   assign last_idx    = BITN_W'(CMD_W) + BITN_W'(len_q);
   assign at_last     = (bitn == last_idx);
   assign run_rise    = (state == ST_RUN) && hstep && !sclk_q;
   assign run_fall    = (state == ST_RUN) && hstep && sclk_q;
   assign frame_start = (!busy && enable) || (run_fall && at_last && enable);
   assign tx_adv      = run_fall && (bitn < BITN_W'(CMD_W));
   assign rx_cap      = run_rise && (bitn > BITN_W'(CMD_W));

   uwire_cfg #(
      .PSC_W     (PSC_W),
      .SCR_W     (SCR_W),
      .LEN_W     (LEN_W),
      .MIN_RSP_W (MIN_RSP_W),
      .MAX_RSP_W (MAX_RSP_W)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (!busy && !enable),
      .psc_in (psc_div),
      .scr_in (scr_val),
      .len_in (rsp_len),
      .half_q (half_q),
      .scr_q  (scr_q),
      .len_q  (len_q)
   );

   uwire_clkdiv #(
      .HW    (HW),
      .SCR_W (SCR_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .half  (half_q),
      .scr   (scr_q),
      .hstep (hstep)
   );

   uwire_shift #(
      .CMD_W (CMD_W),
      .RSP_W (MAX_RSP_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (frame_start),
      .cmd_in  (cmd_byte),
      .tx_adv  (tx_adv),
      .rx_cap  (rx_cap),
      .rxd     (rxd),
      .tx_bit  (tx_bit),
      .rx_next (rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bitn   <= '0;
         lcnt   <= '0;
         sclk_q <= 1'b0;
         fss_q  <= 1'b1;
         done_q <= 1'b0;
         rsp_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (enable) begin
                  state <= ST_LEAD;
                  fss_q <= 1'b0;
                  bitn  <= '0;
                  lcnt  <= '0;
               end
            end
            ST_LEAD: begin
               if (hstep) begin
                  if (lcnt == LCNT_W'(LEAD_STEPS - 1)) state <= ST_RUN;
                  lcnt <= lcnt + LCNT_W'(1);
               end
            end
            ST_RUN: begin
               if (hstep) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     if (at_last) begin
                        done_q <= 1'b1;
                        rsp_q  <= rx_next;
                     end
                  end else begin
                     sclk_q <= 1'b0;
                     if (at_last) begin
                        bitn <= '0;
                        if (!enable) begin
                           state <= ST_IDLE;
                           fss_q <= 1'b1;
                        end
                     end else begin
                        bitn <= bitn + BITN_W'(1);
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sclk     = sclk_q;
   assign fss_n    = fss_q;
   assign txd      = busy && (bitn < BITN_W'(CMD_W)) && tx_bit;
   assign done     = done_q;
   assign rsp_data = rsp_q;

endmodule

// File: rtl/uwire_master_chk.sv
module uwire_master_chk #(
   parameter int CFG_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             sclk,
   input logic             fss_n,
   input logic             txd,
   input logic             done,
   input logic             hstep,
   input logic             busy,
   input logic [CFG_W-1:0] cfg_word
);

   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      fss_n |-> (!sclk && !txd && !done)) else $error("idle lines"); // R1

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R5

   AST_DONE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sclk && !fss_n)) else $error("done off the rising edge"); // R5

   AST_SCLK_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !hstep |=> $stable(sclk)) else $error("sclk moved between steps"); // R6

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_word)) else $error("settings changed while busy"); // R9

   AST_RELEASE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fss_n) |-> !$past(enable)) else $error("select released while enabled"); // R8

endmodule

bind uwire_master uwire_master_chk #(
   .CFG_W (PSC_W - 1 + SCR_W + LEN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .sclk     (sclk),
   .fss_n    (fss_n),
   .txd      (txd),
   .done     (done),
   .hstep    (hstep),
   .busy     (busy),
   .cfg_word ({half_q, scr_q, len_q})
);

// File: tb/tb_uwire_master.sv
module tb_uwire_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        rxd = 1'b0;
   logic [7:0]  cmd_byte = '0;
   logic [7:0]  psc_div = 8'd2;
   logic [7:0]  scr_val = '0;
   logic [4:0]  rsp_len = 5'd8;
   logic        sclk, fss_n, txd, done;
   logic [15:0] rsp_data;

   always #4 clk = ~clk;

   uwire_master dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .cmd_byte (cmd_byte),
      .rsp_len  (rsp_len),
      .psc_div  (psc_div),
      .scr_val  (scr_val),
      .rxd      (rxd),
      .sclk     (sclk),
      .fss_n    (fss_n),
      .txd      (txd),
      .rsp_data (rsp_data),
      .done     (done)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   longint      cyc = 0;
   int          e_h = 1;
   int          e_len = 8;
   logic [7:0]  cmds [8];
   logic [15:0] resps [8];
   int          fidx = 0;
   int          rcount = 0;
   logic        prev_sclk = 1'b0;
   logic        prev_fss = 1'b1;
   logic        rise, fall;
   logic [7:0]  cmd_cap = '0;
   longint      t_fss = 0;
   longint      t_rise = 0;
   bit          seen_rise = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff_half(input int p);
      return ((p / 2) < 1) ? 1 : (p / 2);
   endfunction

   function automatic int eff_len(input int l);
      if (l < 4) return 4;
      if (l > 16) return 16;
      return l;
   endfunction

   // Slave model and line checks, all sampled on the falling system edge.
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
      if (rst_n) begin
         rise = sclk && !prev_sclk;
         fall = !sclk && prev_sclk;
         if (!fss_n && prev_fss) begin
            t_fss = cyc;
            rcount = 0;
            seen_rise = 1'b0;
         end
         if (fss_n && !prev_fss)
            chk(rcount == 0 && !enable, "R10 release at frame boundary", rcount, 0);
         if (rise) begin
            if (!seen_rise)
               chk(cyc - t_fss >= 4 * e_h, "R2 select lead", cyc - t_fss, 4 * e_h);
            else if (rcount == 0)
               chk(cyc - t_rise == 2 * e_h, "R8 back-to-back spacing", cyc - t_rise, 2 * e_h);
            else
               chk(cyc - t_rise == 2 * e_h, "R6 bit period", cyc - t_rise, 2 * e_h);
            seen_rise = 1'b1;
            t_rise = cyc;
            if (rcount < 8) cmd_cap = {cmd_cap[6:0], txd};
            else chk(txd == 1'b0, "R4 txd low after command", txd, 0);
            if (rcount == 8 + e_len) begin
               chk(done == 1'b1, "R5 done on last bit", done, 1);
               chk(rsp_data == resps[fidx], "R5 R4 R7 received word", rsp_data, resps[fidx]);
               chk(cmd_cap == cmds[fidx], "R3 command bits", cmd_cap, cmds[fidx]);
               fidx++;
               rcount = 0;
               if (fidx < 8) cmd_byte = cmds[fidx];
            end else begin
               if (done) chk(1'b0, "R5 done before last bit", done, 0);
               rcount++;
            end
         end else if (done) begin
            chk(1'b0, "R5 done without rising edge", done, 0);
         end
         if (fall) begin
            chk(cyc - t_rise == e_h, "R6 high half", cyc - t_rise, e_h);
            rxd = (rcount >= 9) ? resps[fidx][e_len - 1 - (rcount - 9)] : 1'b0;
         end
         prev_sclk = sclk;
         prev_fss = fss_n;
      end
   end

   task automatic burst(input int p, input int s, input int l, input int n, input bit garble);
      @(negedge clk);
      psc_div = 8'(p);
      scr_val = 8'(s);
      rsp_len = 5'(l);
      e_h = eff_half(p) * (s + 1);
      e_len = eff_len(l);
      for (int i = 0; i < 8; i++) begin
         cmds[i]  = 8'($urandom);
         resps[i] = 16'($urandom & ((1 << e_len) - 1));
      end
      fidx = 0;
      cmd_byte = cmds[0];
      repeat (2) @(negedge clk);
      enable = 1'b1;
      if (garble) begin
         // R9: new settings while enabled must not alter the running burst
         repeat (3) @(negedge clk);
         psc_div = 8'($urandom);
         scr_val = 8'($urandom);
         rsp_len = 5'($urandom);
      end
      while (!(fidx == n - 1 && rcount >= 1)) @(negedge clk);
      enable = 1'b0;
      while (fidx < n) @(negedge clk);
      while (!fss_n) @(negedge clk);
      chk(fidx == n, "R10 frames completed", fidx, n);
      repeat (4) @(negedge clk);
      chk(fss_n && !sclk && !txd && !done, "R1 idle after burst", {fss_n, sclk, txd, done}, 4'b1000);
   endtask

   initial begin
      void'($urandom(32'h5A17C3));
      repeat (3) @(negedge clk);
      chk(fss_n == 1'b1, "R1 fss_n in reset", fss_n, 1);
      chk(sclk == 1'b0 && txd == 1'b0, "R1 sclk/txd in reset", {sclk, txd}, 0);
      chk(done == 1'b0, "R1 done in reset", done, 0);
      chk(rsp_data == 16'd0, "R1 rsp_data in reset", rsp_data, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(fss_n && !sclk && !txd, "R1 idle while disabled", {fss_n, sclk, txd}, 3'b100);

      burst(2, 9, 8, 2, 1'b0);    // 20 system clocks per bit
      burst(2, 0, 4, 3, 1'b0);    // fastest rate, shortest response
      burst(3, 1, 16, 2, 1'b0);   // R6 odd divisor acts as 2; longest response
      burst(0, 2, 0, 2, 1'b0);    // R6 divisor 0 acts as 2; R7 length 0 acts as 4
      burst(4, 1, 31, 2, 1'b1);   // R7 length 31 acts as 16; R9 mid-burst rewrite
      burst(6, 0, 3, 2, 1'b1);    // R7 length 3 acts as 4; R9
      burst(1, 0, 17, 1, 1'b0);   // R7 length 17 acts as 16; single frame
      for (int k = 0; k < 8; k++)
         burst(2 + 2 * int'($urandom % 4), int'($urandom % 6), int'($urandom % 20),
               1 + int'($urandom % 3), 1'($urandom % 2));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule